// File: doc/BRIEF.md
# Truth-Table Configured Bitslice ALU

A combinational arithmetic and logic unit built as a row of identical one-bit slices. The register operand A reaches every slice from the accumulator or program counter side, and the memory operand B from the data bus. Each slice holds two small lookup selectors addressed by its own pair of operand bits. One gives a propagate bit and the other gives a generate bit. A ripple carry chain links the slices. Each result bit is the slice's propagate XOR the carry arriving at that slice.

No opcode is decoded. The controlling logic supplies the truth tables directly: a 4-entry propagate table and a 3-entry generate table. The generate entry for A=0, B=0 is fixed at zero. Left shifts come from the carry chain moving generate bits upward. Right shifts come from a bypass gate that routes the propagate of the next higher slice into each result bit. A polarity input selects whether the carry-in and carry-out ports are active high or active low. The slices are the same in both cases.

Top module: `lsa_alu`

## Requirements
- R1: The table index is {B,A}. Table bit 0 is used for A=0,B=0, bit 1 for A=1,B=0, bit 2 for A=0,B=1 and bit 3 for A=1,B=1. With gen_tbl=000 and shift_right=0, the settings prop_tbl=1000, 0110 and 1110 give A AND B, A XOR B and A OR B respectively, each with carry-in 0.
- R2: With gen_tbl=000, shift_right=0 and carry-in 0, the following settings hold: prop_tbl=0000 gives all zeros, 1111 gives all ones, 1010 passes A and 1100 passes B.
- R3: With gen_tbl=100 and prop_tbl=0110 (add), result = A+B+carry mod 2^16 and carry-out = bit 16 of that sum.
- R4: With gen_tbl=001, prop_tbl=1001 and carry 1, result = A-B mod 2^16. Carry-out is 1 exactly when A >= B (unsigned).
- R5: With gen_tbl=110, prop_tbl=0011 and carry 0, result = B-1 mod 2^16. Carry-out is 1 exactly when B != 0.
- R6: Pass register (gen_tbl=000, prop_tbl=1010) with carry 1 gives A+1. Carry-out is 1 exactly when A = FFFF.
- R7: Shift left has two settings: gen_tbl=101, prop_tbl=0000 for A, and gen_tbl=110, prop_tbl=0000 for B. In both, result = {X[14:0], carry} and carry-out = X[15].
- R8: With shift_right=1 and gen_tbl=000, prop_tbl=1010 gives {carry, A[15:1]} and prop_tbl=1100 gives {carry, B[15:1]}.
- R9: The generate entry for A=0,B=0 is always 0. With gen_tbl=111, prop_tbl=0000 and shift_right=0, the result is {(A|B)[14:0], carry} and the carry-out is (A|B)[15]. For A=B=0 this gives result {15'b0, carry} and carry-out 0.
- R10: With carry_low=1, the carry input and carry output ports are active low. The internal carry is the inverse of carry_in, and carry_out is the inverse of the internal carry-out. This includes the shift-in and fill bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 16 | Register operand A |
| opb | input | 16 | Memory operand B |
| prop_tbl | input | 4 | Propagate truth table, indexed by {B,A} |
| gen_tbl | input | 3 | Generate truth table entries 3..1 (entry 0 fixed 0) |
| shift_right | input | 1 | Route each slice's upper neighbour propagate to its result bit |
| carry_in | input | 1 | Carry into bit 0 (polarity set by carry_low) |
| carry_low | input | 1 | 1: carry ports active low; 0: active high |
| result | output | 16 | ALU result |
| carry_out | output | 1 | Carry out of bit 15 (polarity set by carry_low) |

## Verification
The logic tables are tried with operand pairs that hold all four {B,A} combinations in different bit positions. A swapped or wrong table index therefore shows up as a wrong result bit. Addition, subtraction and decrement are run on random operands and on edge operands (zero, FFFF, A equal to B, B zero). These separate a missing carry link or a wrong carry-out from a correct ripple. The shifts are run with both carry values, which shows whether the fill and shift-in bits come from the carry. The carry chain is also run with the polarity inverted, which exposes a port-level polarity slip. Tables with a fully set generate table and zero operands confirm that the fixed generate entry never creates a carry.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    localparam int unsigned LSA_WIDTH = 16;
    localparam int unsigned TBL_BITS  = 4;

    typedef struct packed {
        logic p;
        logic g;
    } pg_t;

    // look up one entry of a 4-entry gate table, index {b,a}
    function automatic logic tbl_pick(input logic [TBL_BITS-1:0] tbl,
                                      input logic a, input logic b);
        return tbl[{b, a}];
    endfunction

endpackage

// File: rtl/lsa_slice.sv
module lsa_slice
    import lsa_pkg::*;
(
    input  logic                opa_bit,
    input  logic                opb_bit,
    input  logic [3:0]          prop_tbl,
    input  logic [3:1]          gen_tbl,
    output pg_t                 pg_hi,
    output pg_t                 pg_lo
);
    logic [TBL_BITS-1:0] gen_full;

    // entry 0 of the generate table is tied low
    assign gen_full = {gen_tbl, 1'b0};

    // selectors produce active-low signals internally
    assign pg_lo.p = ~tbl_pick(prop_tbl, opa_bit, opb_bit);
    assign pg_lo.g = ~tbl_pick(gen_full, opa_bit, opb_bit);
    assign pg_hi.p = ~pg_lo.p;
    assign pg_hi.g = ~pg_lo.g;

    always_comb begin
        // R9
        gen_zero_entry_chk: assert (!(opa_bit == 1'b0 && opb_bit == 1'b0) || pg_lo.g == 1'b1);
    end
endmodule

// File: rtl/lsa_carry.sv
module lsa_carry
    import lsa_pkg::*;
#(
    parameter int unsigned W = LSA_WIDTH
) (
    input  pg_t [W-1:0]  pg,
    input  logic         c_first,
    output logic [W:0]   c
);
    assign c[0] = c_first;

    for (genvar i = 0; i < W; i++) begin : g_rip
        assign c[i+1] = pg[i].g | (pg[i].p & c[i]);
    end
endmodule

// File: rtl/lsa_result.sv
module lsa_result #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] prop,
    input  logic [W-1:0] c_into,
    input  logic         fill,
    input  logic         shift_right,
    output logic [W-1:0] result
);
    logic [W-1:0] upper;

    for (genvar i = 0; i < W; i++) begin : g_out
        if (i == W - 1) begin : g_top
            assign upper[i] = fill;
        end else begin : g_mid
            assign upper[i] = prop[i+1];
        end
        assign result[i] = shift_right ? upper[i] : (prop[i] ^ c_into[i]);
    end
endmodule

// File: rtl/lsa_alu.sv
module lsa_alu
    import lsa_pkg::*;
#(
    parameter int unsigned W = LSA_WIDTH
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [3:0]   prop_tbl,
    input  logic [2:0]   gen_tbl,
    input  logic         shift_right,
    input  logic         carry_in,
    input  logic         carry_low,
    output logic [W-1:0] result,
    output logic         carry_out
);
    localparam int unsigned WX = W + 1;

    pg_t [W-1:0]  pg_hi;
    pg_t [W-1:0]  pg_lo;
    logic [W-1:0] prop_v;
    logic [W:0]   chain;
    logic         c_int;

    assign c_int = carry_in ^ carry_low;

    for (genvar i = 0; i < W; i++) begin : g_sl
        lsa_slice u_slice (
            .opa_bit  (opa[i]),
            .opb_bit  (opb[i]),
            .prop_tbl (prop_tbl),
            .gen_tbl  (gen_tbl),
            .pg_hi    (pg_hi[i]),
            .pg_lo    (pg_lo[i])
        );
        assign prop_v[i] = pg_hi[i].p;
    end

    lsa_carry #(.W(W)) u_carry (
        .pg      (pg_hi),
        .c_first (c_int),
        .c       (chain)
    );

    lsa_result #(.W(W)) u_res (
        .prop        (prop_v),
        .c_into      (chain[W-1:0]),
        .fill        (c_int),
        .shift_right (shift_right),
        .result      (result)
    );

    assign carry_out = chain[W] ^ carry_low;

    always_comb begin
        // R3
        add_sum_chk: assert (!(shift_right == 1'b0 && prop_tbl == 4'b0110 && gen_tbl == 3'b100)
            || {chain[W], result} == (WX'(opa) + WX'(opb) + WX'(c_int)));
        // R8
        shr_reg_chk: assert (!(shift_right == 1'b1 && prop_tbl == 4'b1010 && gen_tbl == 3'b000)
            || result == {c_int, opa[W-1:1]});
        // R2
        pass_reg_chk: assert (!(shift_right == 1'b0 && prop_tbl == 4'b1010 && gen_tbl == 3'b000
            && c_int == 1'b0) || result == opa);
        // R10
        cout_pol_chk: assert (!(prop_tbl == 4'b0000 && gen_tbl == 3'b000) || carry_out == carry_low);
    end
endmodule

// File: tb/lsa_alu_test.sv
`timescale 1ns/1ps
module lsa_alu_test;
    localparam int W = 16;

    typedef struct {
        logic [W-1:0] exp_r;
        logic         exp_c;
        logic         use_c;
        string        tag;
    } item_t;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [W-1:0] opa, opb, result;
    logic [3:0]   prop_tbl;
    logic [2:0]   gen_tbl;
    logic         shift_right, carry_in, carry_low, carry_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    item_t sb[$];

    lsa_alu uut (
        .opa(opa), .opb(opb), .prop_tbl(prop_tbl), .gen_tbl(gen_tbl),
        .shift_right(shift_right), .carry_in(carry_in), .carry_low(carry_low),
        .result(result), .carry_out(carry_out)
    );

    task automatic drive(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [3:0] ps, input logic [2:0] gs, input logic sr,
                         input logic ci, input logic lo,
                         input logic [W-1:0] er, input logic ec, input logic uc);
        item_t it;
        @(posedge clk);
        #1;
        opa = a; opb = b; prop_tbl = ps; gen_tbl = gs;
        shift_right = sr; carry_in = ci; carry_low = lo;
        it.exp_r = er; it.exp_c = ec; it.use_c = uc; it.tag = tag;
        sb.push_back(it);
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_cmp++;
            if (result !== it.exp_r || (it.use_c && carry_out !== it.exp_c)) begin
                n_bad++;
                $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                         it.tag, result, carry_out, it.exp_r, it.exp_c);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: result=%h expected completion", result);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] a, b;
        logic [W:0]   s;
        logic         c;
        opa = '0; opb = '0; prop_tbl = '0; gen_tbl = '0;
        shift_right = 0; carry_in = 0; carry_low = 0;

        a = 16'h5A3C; b = 16'h33F0;
        // R1 logic tables
        drive("R1 and", a, b, 4'b1000, 3'b000, 0, 0, 0, a & b, 1'b0, 1'b1);
        drive("R1 xor", a, b, 4'b0110, 3'b000, 0, 0, 0, a ^ b, 1'b0, 1'b0);
        drive("R1 or",  a, b, 4'b1110, 3'b000, 0, 0, 0, a | b, 1'b0, 1'b0);
        // R2 constants and pass-through
        drive("R2 zero", a, b, 4'b0000, 3'b000, 0, 0, 0, 16'h0000, 1'b0, 1'b1);
        drive("R2 ones", a, b, 4'b1111, 3'b000, 0, 0, 0, 16'hFFFF, 1'b0, 1'b1);
        drive("R2 passA", a, b, 4'b1010, 3'b000, 0, 0, 0, a, 1'b0, 1'b1);
        drive("R2 passB", a, b, 4'b1100, 3'b000, 0, 0, 0, b, 1'b0, 1'b1);

        // R3 add, random and edges
        for (int k = 0; k < 40; k++) begin
            a = 16'($urandom); b = 16'($urandom); c = 1'($urandom);
            s = {1'b0, a} + {1'b0, b} + {16'b0, c};
            drive("R3 add", a, b, 4'b0110, 3'b100, 0, c, 0, s[W-1:0], s[W], 1'b1);
        end
        drive("R3 add ovf", 16'hFFFF, 16'h0000, 4'b0110, 3'b100, 0, 1, 0, 16'h0000, 1'b1, 1'b1);
        drive("R3 add max", 16'hFFFF, 16'hFFFF, 4'b0110, 3'b100, 0, 1, 0, 16'hFFFF, 1'b1, 1'b1);

        // R4 subtract
        for (int k = 0; k < 40; k++) begin
            a = 16'($urandom); b = (k % 5 == 0) ? a : 16'($urandom);
            drive("R4 sub", a, b, 4'b1001, 3'b001, 0, 1, 0, a - b, (a >= b), 1'b1);
        end
        drive("R4 sub zero", 16'h0000, 16'h0001, 4'b1001, 3'b001, 0, 1, 0, 16'hFFFF, 1'b0, 1'b1);

        // R5 memory minus one
        for (int k = 0; k < 20; k++) begin
            b = (k == 0) ? 16'h0000 : 16'($urandom);
            drive("R5 dec", 16'h1234, b, 4'b0011, 3'b110, 0, 0, 0, b - 16'd1, (b != 0), 1'b1);
        end

        // R6 increment
        drive("R6 inc", 16'h00FF, 16'h0, 4'b1010, 3'b000, 0, 1, 0, 16'h0100, 1'b0, 1'b1);
        drive("R6 inc wrap", 16'hFFFF, 16'h0, 4'b1010, 3'b000, 0, 1, 0, 16'h0000, 1'b1, 1'b1);

        // R7 shift left
        for (int k = 0; k < 10; k++) begin
            a = 16'($urandom); b = 16'($urandom); c = k[0];
            drive("R7 shlA", a, b, 4'b0000, 3'b101, 0, c, 0, {a[W-2:0], c}, a[W-1], 1'b1);
            drive("R7 shlB", a, b, 4'b0000, 3'b110, 0, c, 0, {b[W-2:0], c}, b[W-1], 1'b1);
        end

        // R8 shift right
        for (int k = 0; k < 10; k++) begin
            a = 16'($urandom); b = 16'($urandom); c = k[0];
            drive("R8 shrA", a, b, 4'b1010, 3'b000, 1, c, 0, {c, a[W-1:1]}, 1'b0, 1'b0);
            drive("R8 shrB", a, b, 4'b1100, 3'b000, 1, c, 0, {c, b[W-1:1]}, 1'b0, 1'b0);
        end

        // R9 fixed generate entry
        drive("R9 zero ops", 16'h0, 16'h0, 4'b0000, 3'b111, 0, 0, 0, 16'h0000, 1'b0, 1'b1);
        drive("R9 zero ops ci", 16'h0, 16'h0, 4'b0000, 3'b111, 0, 1, 0, 16'h0001, 1'b0, 1'b1);
        a = 16'h8421; b = 16'h0300;
        drive("R9 or gen", a, b, 4'b0000, 3'b111, 0, 0, 0, {(a | b) << 1}, 1'b1, 1'b1);

        // R10 active-low carry ports
        for (int k = 0; k < 20; k++) begin
            a = 16'($urandom); b = 16'($urandom); c = 1'($urandom);
            s = {1'b0, a} + {1'b0, b} + {16'b0, ~c};
            drive("R10 add lo", a, b, 4'b0110, 3'b100, 0, c, 1, s[W-1:0], ~s[W], 1'b1);
        end
        drive("R10 inc lo", 16'hFFFF, 16'h0, 4'b1010, 3'b000, 0, 0, 1, 16'h0000, 1'b0, 1'b1);
        drive("R10 shr fill lo", 16'h0002, 16'h0, 4'b1010, 3'b000, 1, 0, 1, 16'h8001, 1'b0, 1'b0);
        drive("R10 shl in lo", 16'h0001, 16'h0, 4'b0000, 3'b101, 0, 1, 1, 16'h0002, 1'b1, 1'b1);

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule